// File: doc/BRIEF.md
# Divided Clock Output Stage with Clean Enable Gating

This block takes one of two clocks, either the on-chip VCO clock or the raw reference clock, and divides it by a programmable ratio. The result is sent to a clock output pad. A 7-bit code sets the ratio from 1 to 128. Odd ratios keep a 50% duty cycle because the high phase is stretched by half a source period on the falling edge.

The pad is controlled by an asynchronous enable pin. The enable passes through a two-flop synchroniser clocked by the divided clock, and the gate only opens or closes while the divided clock is low, so no shortened pulse reaches the pad. While the enable is low, a configuration bit selects whether the pad is driven low or released to high impedance.

In configuration-access mode the undivided reference clock is sent straight to the pad, whatever the enable and divider settings are. A pad drive-strength bit is passed through without change.

Top module: `outdiv_gate`

## Requirements
- R1: The 7-bit ratio code k gives divide-by-k for k in 1..127, and code 0 gives divide-by-128.
- R2: With `src_sel_ref` = 0 the VCO clock feeds the divider. With `src_sel_ref` = 1 the reference clock feeds it.
- R3: The high time of the pad clock is exactly half of its period for both even and odd ratios. Ratio 1 passes the source clock through unchanged.
- R4: While the gate is closed and `idle_hiz` = 0, `pad_oe` = 1 and `pad_out` = 0.
- R5: While the gate is closed and `idle_hiz` = 1, `pad_oe` = 0 and `pad_out` = 0.
- R6: After `out_en` falls, no rising edge reaches `pad_out` once two output periods have passed, and the pad then stays low.
- R7: After `out_en` rises, the first rising edge on `pad_out` arrives within two output periods.
- R8: The gate changes state only while the divided clock is low. The first pulse after enabling has the full half-period high time.
- R9: A new ratio code takes effect only at the end of the period in progress. That period completes at the old ratio.
- R10: With `access_mode` = 1, `pad_out` carries the undivided reference clock and `pad_oe` = 1, regardless of `out_en` and `idle_hiz`.
- R11: `drive_strong_out` always equals `drive_strong_in`.
- R12: During reset the gate is closed, so `pad_out` = 0 and `pad_oe` follows R4/R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | VCO clock, one of the two possible divider sources |
| ref_clk | input | 1 | Reference clock, the other divider source and the access-mode output |
| rst_n | input | 1 | Asynchronous reset, active low |
| k_code | input | 7 | Division ratio code; 0 means 128 |
| src_sel_ref | input | 1 | 0 selects the VCO clock as source, 1 selects the reference clock |
| idle_hiz | input | 1 | Pad state while disabled: 0 drives low, 1 is high impedance |
| out_en | input | 1 | Asynchronous output enable pin |
| access_mode | input | 1 | Configuration-access mode: pad carries the undivided reference clock |
| drive_strong_in | input | 1 | Pad drive-strength setting |
| pad_out | output | 1 | Pad data value |
| pad_oe | output | 1 | Pad output enable (1 = drive) |
| drive_strong_out | output | 1 | Pad drive-strength setting, passed through |

## Verification
The bench measures edge times on the pad and compares period and high time for even, odd, unity and maximum ratios on both sources. A divider that loses the falling-edge stretch shows up as a short high time on odd ratios. A code-0 decode error gives a period shorter than 128 source cycles. The bench changes the ratio part-way through a long period and expects the old period to complete; a design that reloads at once produces a truncated period. Enable latency is timed in both directions, and the first pulse after enabling is checked for full width, which exposes an ungated or early gate as a runt pulse or a late start.

// File: rtl/outdiv_pkg.sv
`timescale 1ns/1ps
package outdiv_pkg;

  parameter int unsigned OD_KW = 7;

  // Division ratio selected by a code; the all-zero code means the largest ratio.
  function automatic int unsigned ratio_of(int unsigned code, int unsigned kw);
    return (code == 0) ? (32'd1 << kw) : code;
  endfunction

  // Number of whole source cycles the rising-edge phase stays high.
  function automatic int unsigned half_of(int unsigned ratio);
    return ratio >> 1;
  endfunction

endpackage

// File: rtl/outdiv_core.sv
`timescale 1ns/1ps
module outdiv_core
  import outdiv_pkg::*;
#(
  parameter int unsigned KW = OD_KW
) (
  input  logic          src_clk,
  input  logic          rst_n,
  input  logic [KW-1:0] k_code,
  output logic          div_clk,
  output logic          div_term,
  output logic [KW-1:0] k_act,
  output logic [KW-1:0] cnt_q
);
  localparam int unsigned RW = KW + 1;

  logic          run_q, pos_hi, neg_hi, odd_q, byp_q;
  logic [RW-1:0] ratio_now, ratio_new;

  always_comb begin
    ratio_now = RW'(ratio_of(32'(k_act), KW));
    ratio_new = RW'(ratio_of(32'(k_code), KW));
  end

  // Terminal count: last cycle of a period, or the first edge after reset.
  assign div_term = !run_q || ({1'b0, cnt_q} == ratio_now - RW'(1));

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      k_act  <= '0;
      cnt_q  <= '0;
      pos_hi <= 1'b0;
      odd_q  <= 1'b0;
      byp_q  <= 1'b0;
    end else if (div_term) begin
      run_q  <= 1'b1;
      k_act  <= k_code;
      cnt_q  <= '0;
      pos_hi <= RW'(half_of(32'(ratio_new))) != '0;
      byp_q  <= ratio_new == RW'(1);
      odd_q  <= ratio_new[0] && (ratio_new != RW'(1));
    end else begin
      cnt_q  <= cnt_q + KW'(1);
      pos_hi <= ({1'b0, cnt_q} + RW'(1)) < RW'(half_of(32'(ratio_now)));
    end
  end

  // Half-cycle delayed copy, used to stretch the high phase on odd ratios.
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) neg_hi <= 1'b0;
    else        neg_hi <= pos_hi;
  end

  assign div_clk = byp_q ? src_clk : (pos_hi | (odd_q & neg_hi));

endmodule

// File: rtl/outdiv_en_sync.sv
`timescale 1ns/1ps
module outdiv_en_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic div_clk,
  input  logic rst_n,
  input  logic en_async,
  output logic gate_on
);
  logic [STAGES-2:0] front_q;

  // Front stages capture on the rising edge of the divided clock.
  always_ff @(posedge div_clk or negedge rst_n) begin
    if (!rst_n) front_q <= '0;
    else if (STAGES > 2) front_q <= {front_q[STAGES-3 >= 0 ? STAGES-3 : 0:0], en_async};
    else front_q <= en_async;
  end

  // Last stage updates on the falling edge, so the gate moves only while the clock is low.
  always_ff @(negedge div_clk or negedge rst_n) begin
    if (!rst_n) gate_on <= 1'b0;
    else        gate_on <= front_q[STAGES-2];
  end

endmodule

// File: rtl/outdiv_gate.sv
`timescale 1ns/1ps
module outdiv_gate
  import outdiv_pkg::*;
#(
  parameter int unsigned KW = OD_KW
) (
  input  logic          vco_clk,
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic [KW-1:0] k_code,
  input  logic          src_sel_ref,
  input  logic          idle_hiz,
  input  logic          out_en,
  input  logic          access_mode,
  input  logic          drive_strong_in,
  output logic          pad_out,
  output logic          pad_oe,
  output logic          drive_strong_out
);
  logic          src_clk;
  logic          div_clk;
  logic          div_term;
  logic          gate_on;
  logic [KW-1:0] k_act;
  logic [KW-1:0] cnt_q;

  // Source selection is static configuration.
  assign src_clk = src_sel_ref ? ref_clk : vco_clk;

  outdiv_core #(.KW(KW)) core_i (
    .src_clk  (src_clk),
    .rst_n    (rst_n),
    .k_code   (k_code),
    .div_clk  (div_clk),
    .div_term (div_term),
    .k_act    (k_act),
    .cnt_q    (cnt_q)
  );

  outdiv_en_sync #(.STAGES(2)) sync_i (
    .div_clk  (div_clk),
    .rst_n    (rst_n),
    .en_async (out_en),
    .gate_on  (gate_on)
  );

  always_comb begin
    if (access_mode) begin
      pad_out = ref_clk;
      pad_oe  = 1'b1;
    end else begin
      pad_out = div_clk & gate_on;
      pad_oe  = gate_on | ~idle_hiz;
    end
  end

  assign drive_strong_out = drive_strong_in;

endmodule

// File: rtl/outdiv_gate_chk.sv
`timescale 1ns/1ps
module outdiv_gate_chk
  import outdiv_pkg::*;
#(
  parameter int unsigned KW = OD_KW
) (
  input logic          ref_clk,
  input logic          src_clk,
  input logic          rst_n,
  input logic          div_clk,
  input logic          div_term,
  input logic          gate_on,
  input logic [KW-1:0] k_act,
  input logic [KW-1:0] cnt_q,
  input logic          idle_hiz,
  input logic          access_mode,
  input logic          pad_out,
  input logic          pad_oe
);

  assert_cnt_in_range_R1: assert property (@(posedge src_clk) disable iff (!rst_n)
    32'(cnt_q) < ratio_of(32'(k_act), KW))
    else $error("counter beyond active ratio");

  assert_ratio_at_term_R9: assert property (@(posedge src_clk) disable iff (!rst_n)
    (k_act != $past(k_act)) |-> $past(div_term))
    else $error("ratio switched mid-period");

  assert_hiz_quiet_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !pad_oe |-> (!pad_out && idle_hiz && !access_mode))
    else $error("released pad not in idle high-impedance state");

  assert_access_drives_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    access_mode |-> pad_oe)
    else $error("access mode without pad drive");

  always @(gate_on) begin
    if (rst_n) begin
      assert_gate_in_low_R8: assert (!div_clk)
        else $error("gate moved while divided clock high");
    end
  end

endmodule

bind outdiv_gate outdiv_gate_chk #(.KW(KW)) chk_i (
  .ref_clk     (ref_clk),
  .src_clk     (src_clk),
  .rst_n       (rst_n),
  .div_clk     (div_clk),
  .div_term    (div_term),
  .gate_on     (gate_on),
  .k_act       (k_act),
  .cnt_q       (cnt_q),
  .idle_hiz    (idle_hiz),
  .access_mode (access_mode),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe)
);

// File: tb/outdiv_gate_tb_top.sv
`timescale 1ns/1ps
module outdiv_gate_tb_top;

  localparam real REF_T = 10.0;
  localparam real VCO_T = 8.0;

  logic       vco_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] k_code = 7'd4;
  logic       src_sel_ref = 1'b0;
  logic       idle_hiz = 1'b0;
  logic       out_en = 1'b0;
  logic       access_mode = 1'b0;
  logic       drive_strong_in = 1'b0;
  logic       pad_out, pad_oe, drive_strong_out;

  always #5 ref_clk = ~ref_clk;
  always #4 vco_clk = ~vco_clk;

  outdiv_gate dut_i (
    .vco_clk (vco_clk), .ref_clk (ref_clk), .rst_n (rst_n),
    .k_code (k_code), .src_sel_ref (src_sel_ref), .idle_hiz (idle_hiz),
    .out_en (out_en), .access_mode (access_mode),
    .drive_strong_in (drive_strong_in), .pad_out (pad_out), .pad_oe (pad_oe),
    .drive_strong_out (drive_strong_out)
  );

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  int unsigned rise_n = 0;
  always @(posedge pad_out) rise_n++;

  typedef struct { real per; real hi; string req; } exp_t;
  exp_t sb_q[$];

  task automatic chk_bit(string req, string what, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_time(string req, string what, real act, real exp);
    n_vec++;
    if (act < exp - 0.01 || act > exp + 0.01) begin
      n_bad++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic chk_le(string req, string what, real act, real lim);
    n_vec++;
    if (act > lim) begin
      n_bad++;
      $display("FAIL %s %s: actual %0.3f expected <= %0.3f", req, what, act, lim);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // Driver: one expected (period, high time) item per configuration.
  task automatic expect_wave(real src_t, int ratio, string req);
    exp_t e;
    e.per = src_t * ratio;
    e.hi  = e.per / 2.0;
    e.req = req;
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
  endtask

  task automatic set_cfg(logic [6:0] k, logic sel);
    @(posedge ref_clk); #1.3;
    k_code = k;
    src_sel_ref = sel;
    #2200;
  endtask

  // Monitor: measures the pad waveform for each queued item.
  initial begin
    forever begin
      real t0, t1, t2;
      wait (sb_q.size() > 0);
      @(posedge pad_out); t0 = $realtime;
      @(negedge pad_out); t1 = $realtime;
      @(posedge pad_out); t2 = $realtime;
      chk_time(sb_q[0].req, "period", t2 - t0, sb_q[0].per);
      chk_time(sb_q[0].req, "high time", t1 - t0, sb_q[0].hi);
      sb_q.delete(0);
    end
  end

  initial begin
    repeat (150000) @(posedge ref_clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    real t0, t1, t2;
    int unsigned n0;
    // R12: reset state, gate closed, driven low
    #23.3;
    chk_bit("R12", "pad_out in reset", pad_out, 1'b0);
    chk_bit("R12", "pad_oe in reset", pad_oe, 1'b1);
    // R11: drive strength passthrough
    drive_strong_in = 1'b1; #1;
    chk_bit("R11", "drive strong", drive_strong_out, 1'b1);
    drive_strong_in = 1'b0; #1;
    chk_bit("R11", "drive weak", drive_strong_out, 1'b0);
    @(posedge ref_clk); #1.3;
    rst_n = 1'b1;
    // R4: enable low keeps pad driven low
    n0 = rise_n;
    #300;
    chk_bit("R4", "no edges while disabled", rise_n == n0, 1'b1);
    chk_bit("R4", "pad_oe disabled", pad_oe, 1'b1);
    chk_bit("R4", "pad_out disabled", pad_out, 1'b0);
    // R7/R8: start latency and first pulse width, K=4 on VCO (P=32)
    @(posedge ref_clk); #1.3;
    out_en = 1'b1; t0 = $realtime;
    @(posedge pad_out); t1 = $realtime;
    @(negedge pad_out); t2 = $realtime;
    chk_le("R7", "start latency", t1 - t0, 2.0 * VCO_T * 4);
    chk_time("R8", "first pulse high", t2 - t1, VCO_T * 2);
    // R1/R3 ratios on the VCO
    expect_wave(VCO_T, 4, "R1");
    set_cfg(7'd5, 1'b0);   expect_wave(VCO_T, 5, "R3");
    set_cfg(7'd1, 1'b0);   expect_wave(VCO_T, 1, "R3");
    set_cfg(7'd7, 1'b0);   expect_wave(VCO_T, 7, "R3");
    set_cfg(7'd0, 1'b0);   expect_wave(VCO_T, 128, "R1");
    // R2: reference as source
    set_cfg(7'd2, 1'b1);   expect_wave(REF_T, 2, "R2");
    set_cfg(7'd3, 1'b1);   expect_wave(REF_T, 3, "R2");
    // R9: ratio change mid-period completes the old period
    set_cfg(7'd10, 1'b0);
    @(posedge pad_out); t0 = $realtime;
    #9.3; k_code = 7'd4;
    @(posedge pad_out); t1 = $realtime;
    @(posedge pad_out); t2 = $realtime;
    chk_time("R9", "old period kept", t1 - t0, VCO_T * 10);
    chk_time("R9", "new period", t2 - t1, VCO_T * 4);
    #400;
    // R6: stop latency, K=4 (P=32)
    @(posedge ref_clk); #1.3;
    out_en = 1'b0;
    #64;
    n0 = rise_n;
    chk_bit("R6", "low two periods after disable", pad_out, 1'b0);
    #500;
    chk_bit("R6", "no edges after stop", rise_n == n0, 1'b1);
    chk_bit("R4", "pad_oe after stop", pad_oe, 1'b1);
    // R5: high-impedance idle
    idle_hiz = 1'b1; #20;
    chk_bit("R5", "pad_oe released", pad_oe, 1'b0);
    chk_bit("R5", "pad_out low when released", pad_out, 1'b0);
    // R10: access mode routes reference clock, ignoring enable and idle state
    @(posedge ref_clk); #1.3;
    access_mode = 1'b1; #50;
    chk_bit("R10", "pad_oe in access", pad_oe, 1'b1);
    expect_wave(REF_T, 1, "R10");
    @(posedge ref_clk); #1.3;
    access_mode = 1'b0; #50;
    chk_bit("R5", "pad_oe after access", pad_oe, 1'b0);
    summary();
  end

endmodule